// File: doc/BRIEF.md
# Ethernet Statistics Counter Bank

This block keeps the per-port receive and transmit statistics of an Ethernet MAC. The receive and transmit datapaths each present one status pulse per finished frame, carrying the frame length and a set of classification flags. The bank turns each pulse into increments of the matching counters: octets, frames, flag counters and one RMON length bucket. A separate pulse counts frames that were cut for exceeding the maximum packet size.

Software reads the bank through a single read port. Every read clears the counter it returns. The wide octet and frame counters are read as a low word followed by a high word. The low read captures the upper bits into a shadow register, so that the pair of reads stays coherent even while traffic continues. A global clear input zeroes the whole bank in one cycle. Counters stop at their maximum value and never wrap.

Top module: `rmon_stat_bank`

## Requirements
- R1: A read of a narrow counter (addresses 8 to 34) or of the low word of a wide counter returns the value and clears that counter. A second read returns only the events counted since the first read.
- R2: Each wide counter is WIDE_W bits (45 by default). A read of its low word (even address 0, 2, 4, 6) returns bits RD_W-1:0 and copies the remaining upper bits into a shadow register. A read of its high word (odd address 1, 3, 5, 7) returns that shadow zero-extended and clears nothing. Address 0/1 holds receive octets, 2/3 receive frames, 4/5 transmit octets and 6/7 transmit frames.
- R3: Every valid frame increments exactly one length bucket. The bucket bounds are: length up to 64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, and 1519 or more. Receive buckets sit at addresses 16 to 22 in that order; transmit buckets sit at 27 to 33.
- R4: While rx_valid is high, each set bit of rx_flags increments its own counter. Bit 0 is multicast (addr 8), 1 broadcast (9), 2 FCS error (10), 3 pause (11), 4 jabber (12), 5 short (13), 6 symbol error (14) and 7 oversize (15).
- R5: While tx_valid is high, each set bit of tx_flags increments its own counter. Bit 0 is multicast (addr 23), 1 broadcast (24), 2 pause (25) and 3 general error covering bad FCS and underrun (26).
- R6: Every counter saturates at its all-ones value instead of wrapping.
- R7: In the cycle after clear_all, every counter and every shadow is zero. Events in the clear_all cycle are dropped. A read issued in the clear_all cycle returns the value from before the clear.
- R8: Address 34 counts max_pkt_evt pulses in NAR_W-1 bits. Bit NAR_W-1 of the returned word (bit 31 by default) carries max_pkt_status as sampled in the read cycle and is never part of the count.
- R9: rd_valid and rd_data appear one cycle after rd_en. Without a read, rd_valid is 0 and rd_data is 0, including after reset.
- R10: A read of an address from 35 to 63 returns 0 and changes no counter.
- R11: When an increment and a clearing read reach the same counter in the same cycle, the read returns the old value and the counter restarts at the increment.
- R12: A valid frame adds its length to its direction's octet counter and adds one to its frame counter. Inputs are ignored while their valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_all | input | 1 | Zero every counter and shadow |
| rx_valid | input | 1 | Receive frame-end pulse |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_flags | input | 8 | Receive classification flags (R4) |
| tx_valid | input | 1 | Transmit frame-end pulse |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_flags | input | 4 | Transmit classification flags (R5) |
| max_pkt_evt | input | 1 | Frame exceeded the maximum packet size |
| max_pkt_status | input | 1 | Status bit returned at the top of address 34 |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | RD_W | Read data |

## Verification
The assertions check the read-port properties on every cycle. These are the one-cycle read timing and the idle-zero output, the zero returned for unmapped addresses, and the zero returned right after a global clear. They also check the status bit on the over-size counter, the width bound of a high-word read, the one-hot length bin, and that a repeated read returns zero when no event came in between. The bench's reference model covers the rest, because only directed scenarios can show it. That part covers bucket edges at 64/65 and 1518/1519, shadow coherence when traffic arrives between the low and high reads, saturation of both narrow and wide counters, and a read colliding with an increment.

// File: rtl/rmon_pkg.sv
// Shared constants of the statistics bank: address map and flag counts.
// Assumes a six-bit read address; addresses above LAST_ADDR read as zero.
package rmon_pkg;
    localparam int ADDR_W      = 6;
    localparam int NUM_WIDE    = 4;   // rx octets, rx frames, tx octets, tx frames
    localparam int NUM_BINS    = 7;   // RMON length buckets
    localparam int RX_FLAG_N   = 8;
    localparam int TX_FLAG_N   = 4;
    localparam int NAR_BASE    = 2 * NUM_WIDE;                       // 8
    localparam int RX_BIN_BASE = NAR_BASE + RX_FLAG_N;               // 16
    localparam int TX_FL_BASE  = RX_BIN_BASE + NUM_BINS;             // 23
    localparam int TX_BIN_BASE = TX_FL_BASE + TX_FLAG_N;             // 27
    localparam int NUM_NAR     = 2 * NUM_BINS + RX_FLAG_N + TX_FLAG_N; // 26
    localparam int ADDR_MAXPKT = NAR_BASE + NUM_NAR;                 // 34
    localparam int NUM_ADDR    = ADDR_MAXPKT + 1;                    // 35
endpackage

// File: rtl/rmon_len_bin.sv
// Maps a frame length to a one-hot RMON bucket vector.
// Assumes lengths below 64 (runts) fall into the lowest bucket.
module rmon_len_bin #(
    parameter int LEN_W = 14
) (
    input  logic [LEN_W-1:0] len,
    output logic [6:0]       bin
);
    localparam int LW = (LEN_W < 16) ? 16 : LEN_W;

    logic [LW-1:0] l;

    // Pick the single bucket whose upper bound first covers the length.
    always_comb begin
        l   = LW'(len);
        bin = '0;
        if      (l <= LW'(64))   bin[0] = 1'b1;
        else if (l <= LW'(127))  bin[1] = 1'b1;
        else if (l <= LW'(255))  bin[2] = 1'b1;
        else if (l <= LW'(511))  bin[3] = 1'b1;
        else if (l <= LW'(1023)) bin[4] = 1'b1;
        else if (l <= LW'(1518)) bin[5] = 1'b1;
        else                     bin[6] = 1'b1;
    end
endmodule

// File: rtl/rmon_sat_ctr.sv
// Saturating counter with clear-on-read and a global clear.
// Assumes INC_W <= W; a read in the same cycle as an increment restarts at inc.
module rmon_sat_ctr #(
    parameter int W     = 32,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             rd_clr,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);
    logic [W-1:0] base;
    logic [W:0]   sum;
    logic [W-1:0] nxt;

    // Form the next value: restart on read, clamp at all-ones.
    always_comb begin
        base = rd_clr ? '0 : cnt;
        sum  = {1'b0, base} + {{(W + 1 - INC_W){1'b0}}, inc};
        nxt  = sum[W] ? '1 : sum[W-1:0];
    end

    // Hold the count; the global clear wins over any event.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr_all) cnt <= '0;
        else              cnt <= nxt;
    end
endmodule

// File: rtl/rmon_wide_ctr.sv
// Wide saturating counter read as two words; a low read captures the upper
// bits in a shadow so the following high read matches it. Assumes W > RD_W.
module rmon_wide_ctr #(
    parameter int W     = 45,
    parameter int RD_W  = 32,
    parameter int INC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             rd_lo,
    input  logic [INC_W-1:0] inc,
    output logic [RD_W-1:0]  lo_word,
    output logic [RD_W-1:0]  hi_word
);
    logic [W-1:0] cnt;

    rmon_sat_ctr #(.W(W), .INC_W(INC_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .rd_clr  (rd_lo),
        .inc     (inc),
        .cnt     (cnt)
    );

    assign lo_word = cnt[RD_W-1:0];

    // Capture the upper part of the count at each low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_word <= '0;
        else if (clr_all) hi_word <= '0;
        else if (rd_lo)   hi_word <= RD_W'(cnt[W-1:RD_W]);
    end
endmodule

// File: rtl/rmon_stat_bank.sv
// Per-port RX/TX statistics bank with clear-on-read register access.
// Assumes NAR_W <= RD_W < WIDE_W and LEN_W <= WIDE_W; one read per cycle.
module rmon_stat_bank
    import rmon_pkg::*;
#(
    parameter int LEN_W  = 14,
    parameter int RD_W   = 32,
    parameter int NAR_W  = 32,
    parameter int WIDE_W = 45
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_all,
    input  logic                 rx_valid,
    input  logic [LEN_W-1:0]     rx_len,
    input  logic [RX_FLAG_N-1:0] rx_flags,
    input  logic                 tx_valid,
    input  logic [LEN_W-1:0]     tx_len,
    input  logic [TX_FLAG_N-1:0] tx_flags,
    input  logic                 max_pkt_evt,
    input  logic                 max_pkt_status,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_valid,
    output logic [RD_W-1:0]      rd_data
);
    localparam int MP_W = NAR_W - 1;

    logic [NUM_BINS-1:0] rx_bin, tx_bin;
    logic [NUM_ADDR-1:0] rd_hit;
    logic [NUM_NAR-1:0]  nar_evt;
    logic [LEN_W-1:0]    w_inc [NUM_WIDE];
    logic [RD_W-1:0]     w_lo  [NUM_WIDE];
    logic [RD_W-1:0]     w_hi  [NUM_WIDE];
    logic [NAR_W-1:0]    nar_cnt [NUM_NAR];
    logic [MP_W-1:0]     mp_cnt;
    logic [RD_W-1:0]     rd_word;

    rmon_len_bin #(.LEN_W(LEN_W)) u_rx_bin (.len(rx_len), .bin(rx_bin));
    rmon_len_bin #(.LEN_W(LEN_W)) u_tx_bin (.len(tx_len), .bin(tx_bin));

    // Decode one select line per mapped address.
    for (genvar a = 0; a < NUM_ADDR; a++) begin : g_hit
        assign rd_hit[a] = rd_en && (rd_addr == ADDR_W'(a));
    end

    // Gate every per-frame event with its direction's valid.
    always_comb begin
        nar_evt = {tx_bin   & {NUM_BINS{tx_valid}},
                   tx_flags & {TX_FLAG_N{tx_valid}},
                   rx_bin   & {NUM_BINS{rx_valid}},
                   rx_flags & {RX_FLAG_N{rx_valid}}};
        w_inc[0] = rx_valid ? rx_len : '0;
        w_inc[1] = LEN_W'(rx_valid);
        w_inc[2] = tx_valid ? tx_len : '0;
        w_inc[3] = LEN_W'(tx_valid);
    end

    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
        rmon_wide_ctr #(.W(WIDE_W), .RD_W(RD_W), .INC_W(LEN_W)) u_wide (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_all (clear_all),
            .rd_lo   (rd_hit[2*g]),
            .inc     (w_inc[g]),
            .lo_word (w_lo[g]),
            .hi_word (w_hi[g])
        );
    end

    for (genvar g = 0; g < NUM_NAR; g++) begin : g_nar
        rmon_sat_ctr #(.W(NAR_W), .INC_W(1)) u_nar (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_all (clear_all),
            .rd_clr  (rd_hit[NAR_BASE+g]),
            .inc     (nar_evt[g]),
            .cnt     (nar_cnt[g])
        );
    end

    rmon_sat_ctr #(.W(MP_W), .INC_W(1)) u_maxpkt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clear_all),
        .rd_clr  (rd_hit[ADDR_MAXPKT]),
        .inc     (max_pkt_evt),
        .cnt     (mp_cnt)
    );

    // Select the word for the addressed counter; unmapped reads give zero.
    always_comb begin
        rd_word = '0;
        for (int g = 0; g < NUM_WIDE; g++) begin
            if (rd_hit[2*g])   rd_word = w_lo[g];
            if (rd_hit[2*g+1]) rd_word = w_hi[g];
        end
        for (int g = 0; g < NUM_NAR; g++) begin
            if (rd_hit[NAR_BASE+g]) rd_word = RD_W'(nar_cnt[g]);
        end
        if (rd_hit[ADDR_MAXPKT]) rd_word = RD_W'({max_pkt_status, mp_cnt});
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_word : '0;
        end
    end
endmodule

// File: rtl/rmon_stat_bank_chk.sv
// Cycle-level properties of the statistics bank read port.
// Assumes it is bound into rmon_stat_bank with matching parameters.
module rmon_stat_bank_chk
    import rmon_pkg::*;
#(
    parameter int RD_W   = 32,
    parameter int NAR_W  = 32,
    parameter int WIDE_W = 45
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clear_all,
    input logic                 rx_valid,
    input logic [RX_FLAG_N-1:0] rx_flags,
    input logic [NUM_BINS-1:0]  rx_bin,
    input logic                 max_pkt_status,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic                 rd_valid,
    input logic [RD_W-1:0]      rd_data
);
    localparam int HI_W = WIDE_W - RD_W;
    localparam logic [ADDR_W-1:0] A_BCAST = ADDR_W'(NAR_BASE + 1);
    localparam logic [ADDR_W-1:0] A_MAXP  = ADDR_W'(ADDR_MAXPKT);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && rd_data == '0));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr >= ADDR_W'(NUM_ADDR)) |=> rd_data == '0);

    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all ##1 (rd_en && rd_addr != A_MAXP) |=> rd_data == '0);

    a_r8_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_MAXP) |=> rd_data[NAR_W-1] == $past(max_pkt_status));

    a_r2_hi_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr < ADDR_W'(NAR_BASE) && rd_addr[0]) |=> (rd_data >> HI_W) == '0);

    a_r3_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rx_bin));

    a_r1_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_BCAST && !clear_all && !(rx_valid && rx_flags[1]))
        ##1 (rd_en && rd_addr == A_BCAST) |=> rd_data == '0);
endmodule

bind rmon_stat_bank rmon_stat_bank_chk #(
    .RD_W(RD_W), .NAR_W(NAR_W), .WIDE_W(WIDE_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear_all      (clear_all),
    .rx_valid       (rx_valid),
    .rx_flags       (rx_flags),
    .rx_bin         (rx_bin),
    .max_pkt_status (max_pkt_status),
    .rd_en          (rd_en),
    .rd_addr        (rd_addr),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data)
);

// File: tb/rmon_stat_bank_tb_top.sv
// Bench: behavioural reference model compared with the read port every cycle.
module rmon_stat_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W  = 14;
    localparam int RD_W   = 16;
    localparam int NAR_W  = 12;
    localparam int WIDE_W = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_all = 1'b0;
    logic rx_valid = 1'b0, tx_valid = 1'b0;
    logic [LEN_W-1:0] rx_len = '0, tx_len = '0;
    logic [7:0] rx_flags = '0;
    logic [3:0] tx_flags = '0;
    logic max_pkt_evt = 1'b0, max_pkt_status = 1'b0;
    logic rd_en = 1'b0;
    logic [5:0] rd_addr = '0;
    logic rd_valid;
    logic [RD_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R9";

    longint m [0:34];
    bit      exp_v = 0;
    longint  exp_d = 0;

    rmon_stat_bank #(.LEN_W(LEN_W), .RD_W(RD_W), .NAR_W(NAR_W), .WIDE_W(WIDE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
        .rx_valid(rx_valid), .rx_len(rx_len), .rx_flags(rx_flags),
        .tx_valid(tx_valid), .tx_len(tx_len), .tx_flags(tx_flags),
        .max_pkt_evt(max_pkt_evt), .max_pkt_status(max_pkt_status),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint lim(int a);
        if (a < 8)  return (64'd1 << WIDE_W) - 1;
        if (a < 34) return (64'd1 << NAR_W) - 1;
        return (64'd1 << (NAR_W - 1)) - 1;
    endfunction

    function automatic int bin_of(int l);
        if (l <= 64)   return 0;
        if (l <= 127)  return 1;
        if (l <= 255)  return 2;
        if (l <= 511)  return 3;
        if (l <= 1023) return 4;
        if (l <= 1518) return 5;
        return 6;
    endfunction

    task automatic add(int a, longint v);
        m[a] = (m[a] + v > lim(a)) ? lim(a) : m[a] + v;
    endtask

    // One model step using the inputs presented this cycle.
    task automatic model_step();
        int a;
        a = int'(rd_addr);
        exp_v = rd_en;
        exp_d = 0;
        if (rd_en) begin
            if (a < 8)       exp_d = a[0] ? m[a] : (m[a] & ((64'd1 << RD_W) - 1));
            else if (a < 34) exp_d = m[a];
            else if (a == 34) exp_d = m[a] | (longint'(max_pkt_status) << (NAR_W - 1));
        end
        if (clear_all) begin
            for (int i = 0; i < 35; i++) m[i] = 0;
            return;
        end
        if (rd_en) begin
            if (a < 8 && !a[0]) begin
                m[a+1] = m[a] >> RD_W;
                m[a] = 0;
            end else if (a >= 8 && a <= 34) m[a] = 0;
        end
        if (rx_valid) begin
            add(0, longint'(rx_len)); add(2, 1);
            for (int f = 0; f < 8; f++) if (rx_flags[f]) add(8 + f, 1);
            add(16 + bin_of(int'(rx_len)), 1);
        end
        if (tx_valid) begin
            add(4, longint'(tx_len)); add(6, 1);
            for (int f = 0; f < 4; f++) if (tx_flags[f]) add(23 + f, 1);
            add(27 + bin_of(int'(tx_len)), 1);
        end
        if (max_pkt_evt) add(34, 1);
    endtask

    // Advance one clock, compare at the falling edge, then idle the inputs.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        checks++;
        if (rd_valid !== exp_v || rd_data !== RD_W'(exp_d)) begin
            errors++;
            $display("FAIL %s: rd_valid=%0b rd_data=%0d expected valid=%0b data=%0d",
                     tag, rd_valid, rd_data, exp_v, RD_W'(exp_d));
        end
        clear_all = 0; rx_valid = 0; tx_valid = 0; rx_flags = '0; tx_flags = '0;
        max_pkt_evt = 0; rd_en = 0;
    endtask

    task automatic rx(int len, logic [7:0] fl);
        rx_valid = 1; rx_len = LEN_W'(len); rx_flags = fl;
    endtask

    task automatic tx(int len, logic [3:0] fl);
        tx_valid = 1; tx_len = LEN_W'(len); tx_flags = fl;
    endtask

    task automatic rd(int a);
        rd_en = 1; rd_addr = 6'(a); tick();
    endtask

    task automatic read_all();
        for (int a = 0; a < 35; a++) rd(a);
    endtask

    initial begin
        for (int i = 0; i < 35; i++) m[i] = 0;
        repeat (3) @(negedge clk);
        // R9: reset state of the read port.
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== '0) begin
            errors++;
            $display("FAIL R9 reset: valid=%0b data=%0d expected 0 0", rd_valid, rd_data);
        end
        rst_n = 1;
        tick();

        // R12, R3: octet/frame counts and bucket edges, both directions.
        tag = "R12/R3";
        begin
            int lens [12] = '{40, 64, 65, 127, 128, 255, 256, 511, 1023, 1518, 1519, 9000};
            for (int i = 0; i < 12; i++) begin
                rx(lens[i], 8'h00); tx(lens[11 - i], 4'h0); tick();
            end
        end
        rx_valid = 0; rx_len = 14'd500; tick();   // R12: length ignored without valid
        read_all();

        // R4, R5: flag patterns.
        tag = "R4/R5";
        rx(70, 8'hA5); tx(70, 4'h5); tick();
        rx(70, 8'h5A); tx(70, 4'hA); tick();
        rx(70, 8'hFF); tx(70, 4'hF); tick();
        rx_flags = 8'hFF; tx_flags = 4'hF; tick();   // flags without valid
        read_all();

        // R2: high word coherent with the low read despite later traffic.
        tag = "R2";
        for (int i = 0; i < 10; i++) begin rx(16000, 8'h00); tick(); end
        rd(0);
        for (int i = 0; i < 6; i++) begin rx(16000, 8'h00); tick(); end
        rd(1); rd(1);
        rd(0); rd(1);

        // R11: increment and read of the same counter in one cycle.
        tag = "R11";
        rx(80, 8'h02); tick();
        rx(80, 8'h02); tick();
        rx(80, 8'h02); rd_en = 1; rd_addr = 6'd9; tick();
        rd(9);
        // R1: repeated read returns zero.
        tag = "R1";
        rd(9); rd(17);

        // R6: saturation of narrow and wide counters.
        tag = "R6";
        for (int i = 0; i < 4100; i++) begin rx(64, 8'h02); tick(); end
        rd(9);
        for (int i = 0; i < 260; i++) begin tx(16383, 4'h0); tick(); end
        rd(4); rd(5);
        for (int i = 0; i < 2100; i++) begin max_pkt_evt = 1; tick(); end
        // R8: status bit set and clear on the over-size counter.
        tag = "R8";
        max_pkt_status = 1; rd(34);
        max_pkt_evt = 1; tick();
        max_pkt_status = 0; rd(34);

        // R7: global clear drops same-cycle events; same-cycle read sees old value.
        tag = "R7";
        rx(300, 8'hFF); tx(300, 4'hF); tick();
        rx(300, 8'hFF); clear_all = 1; rd_en = 1; rd_addr = 6'd2; tick();
        read_all();

        // R10: unmapped addresses.
        tag = "R10";
        rx(90, 8'h01); tick();
        rd(35); rd(63); rd(8);

        // Mixed traffic with random reads against the model.
        tag = "R1/R12";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 1) == 1) rx(int'($urandom_range(20, 3000)), 8'($urandom));
            if ($urandom_range(0, 1) == 1) tx(int'($urandom_range(20, 3000)), 4'($urandom));
            max_pkt_evt = $urandom_range(0, 3) == 0;
            max_pkt_status = 1'($urandom);
            clear_all = $urandom_range(0, 199) == 0;
            if ($urandom_range(0, 2) == 0) begin rd_en = 1; rd_addr = 6'($urandom_range(0, 40)); end
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule